// File: doc/BRIEF.md
# Run-Time Reconfigurable Multi-Precision Floating-Point Multiplier

This block multiplies two floating-point operands whose precision is chosen for each operation by a mode tag carried inside the operand words. Each 67-bit word has three parts. The top three bits select one of five significand widths, or an automatic choice. Below the tag sit a sign bit, an 11-bit biased exponent and a 52-bit fraction. Before the multiply, each significand is cut to the selected width. This trades accuracy for less partial-product work.

The datapath is a two-stage pipeline. In stage one, both operands are decoded, the operand classes (number, zero, infinity, NaN) are found, the effective width is resolved and the significands are truncated. In stage two, the truncated significands are multiplied and the product is normalized. The result is then packed, with saturation on exponent overflow and a flush to zero on underflow. Four flags tell the caller whether the result is zero, infinite, NaN, or a flushed underflow.

Top module: `fpm_mul_top`

## Requirements
- R1: Word layout is mode[66:64], sign[63], exponent[62:52] (bias 1023), fraction[51:0]. Modes 1, 2, 3, 4, 5 select significand widths of 8, 16, 23, 36 and 53 bits, counting the hidden 1. Significand bits below that width are cleared in both operands. The result fraction is also cut to the same width by dropping low bits, with no rounding.
- R2: Mode 0 is automatic. For that operand, the width is the smallest of 8, 16, 23, 36 and 53 for which truncation discards only zero bits.
- R3: The result's mode field copies operand A's mode. When both operands are automatic, the larger of their two widths is used. In every other case, the smaller of the two operand widths is used.
- R4: The result sign is the XOR of the operand signs for numbers, zeros and infinities.
- R5: For normal results, the result exponent is expA + expB − 1023. One is added when the truncated significand product is 2 or more, and in that case the product is shifted right by one.
- R6: A biased result exponent of 2047 or more gives a signed infinity (exponent 2047, fraction 0) with only the infinity flag set.
- R7: A biased result exponent of 0 or less gives a signed zero (exponent 0, fraction 0) with both the zero flag and the denormal flag set.
- R8: A mode code of 6 or 7 in either operand gives NaN with only the NaN flag set. The NaN has sign 0, exponent 2047 and fraction 0x8000000000000.
- R9: A NaN operand (exponent 2047, nonzero fraction), or infinity times zero, gives the same NaN as R8.
- R10: An operand with exponent field 0 counts as zero, whatever its fraction. Zero times a number gives signed zero with only the zero flag set. Infinity times a number or infinity gives signed infinity with only the infinity flag set.
- R11: res_valid_o rises exactly two clock cycles after in_valid_i. The result word and the flags stay unchanged in every cycle that does not bring a new result. Reset clears all outputs to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid_i | input | 1 | Operands are valid this cycle |
| op_a_i | input | 67 | Operand A word (its mode is carried to the result) |
| op_b_i | input | 67 | Operand B word |
| res_valid_o | output | 1 | Result word and flags are valid |
| res_o | output | 67 | Result word |
| flag_zero_o | output | 1 | Result is zero |
| flag_inf_o | output | 1 | Result is infinity |
| flag_nan_o | output | 1 | Result is NaN |
| flag_denorm_o | output | 1 | Result underflowed and was flushed to zero |

## Verification
Two pieces of logic can act on the same result in one cycle: the normalization carry and the exponent-range limits. The carry can push a result exponent of 2046 into overflow, or lift a sum of 0 out of underflow. These cases are provoked with operand exponents that sum exactly to the limits, paired once with significands whose product reaches 2 and once with significands whose product stays below 2. Each result is judged against a behavioural model in the bench, which cycle by cycle applies width resolution, truncation, normalization and saturation. The same comparison covers back-to-back operations with mixed modes, where the width chosen for one result must not leak into the next.

// File: rtl/fpm_pkg.sv
package fpm_pkg;
    localparam int MODE_W    = 3;
    localparam int EXP_W     = 11;
    localparam int FRAC_W    = 52;
    localparam int SIG_W     = FRAC_W + 1;
    localparam int WORD_W    = MODE_W + 1 + EXP_W + FRAC_W;
    localparam int EXP_BIAS  = (1 << (EXP_W - 1)) - 1;
    localparam int EXP_MAX   = (1 << EXP_W) - 1;
    localparam int NUM_PREC  = 5;
    localparam int SEXP_W    = EXP_W + 2;
    localparam int PREC_LIST [NUM_PREC] = '{8, 16, 23, 36, 53};

    typedef logic [5:0] wid_t;

    typedef enum logic [1:0] {
        CLS_NUM,
        CLS_ZERO,
        CLS_INF,
        CLS_NAN
    } cls_e;

    // Mask that keeps the top w bits of a significand.
    function automatic logic [SIG_W-1:0] keep_mask(input wid_t w);
        return {SIG_W{1'b1}} << (6'(SIG_W) - w);
    endfunction
endpackage

// File: rtl/fpm_operand_decode.sv
module fpm_operand_decode
    import fpm_pkg::*;
(
    input  logic [WORD_W-1:0] word_i,
    output logic              illegal_o,
    output logic              auto_o,
    output logic              sign_o,
    output logic [EXP_W-1:0]  exp_o,
    output logic [SIG_W-1:0]  sig_o,
    output wid_t              width_o,
    output cls_e              cls_o
);
    logic [MODE_W-1:0] mode;
    logic [FRAC_W-1:0] frac;
    logic [NUM_PREC-1:0] fits;
    wid_t auto_w;

    assign mode   = word_i[WORD_W-1 -: MODE_W];
    assign sign_o = word_i[FRAC_W+EXP_W];
    assign exp_o  = word_i[FRAC_W +: EXP_W];
    assign frac   = word_i[FRAC_W-1:0];
    assign sig_o  = {1'b1, frac};

    assign illegal_o = (mode > MODE_W'(NUM_PREC));
    assign auto_o    = (mode == '0);

    // A width fits when truncation to it throws away only zero bits.
    for (genvar i = 0; i < NUM_PREC; i++) begin : g_fit
        assign fits[i] = ((sig_o & ~keep_mask(wid_t'(PREC_LIST[i]))) == '0);
    end

    // R2: pick the narrowest width that fits.
    always_comb begin
        auto_w = wid_t'(SIG_W);
        for (int i = NUM_PREC - 1; i >= 0; i--) begin
            if (fits[i]) auto_w = wid_t'(PREC_LIST[i]);
        end
    end

    always_comb begin
        width_o = wid_t'(SIG_W);
        if (auto_o) begin
            width_o = auto_w;
        end else begin
            for (int i = 0; i < NUM_PREC; i++) begin
                if (mode == MODE_W'(i + 1)) width_o = wid_t'(PREC_LIST[i]);
            end
        end
    end

    always_comb begin
        if (exp_o == '0)                 cls_o = CLS_ZERO;
        else if (exp_o == EXP_W'(EXP_MAX)) cls_o = (frac == '0) ? CLS_INF : CLS_NAN;
        else                             cls_o = CLS_NUM;
    end
endmodule

// File: rtl/fpm_mant_core.sv
module fpm_mant_core
    import fpm_pkg::*;
(
    input  logic [SIG_W-1:0]         sig_a_i,
    input  logic [SIG_W-1:0]         sig_b_i,
    input  wid_t                     width_i,
    input  logic signed [SEXP_W-1:0] exp_i,
    output logic [FRAC_W-1:0]        frac_o,
    output logic signed [SEXP_W-1:0] exp_o
);
    localparam int PROD_W = 2 * SIG_W;

    logic [PROD_W-1:0] prod;
    logic              carry;
    logic [FRAC_W-1:0] frac_raw;
    logic [SIG_W-1:0]  mask;

    assign prod  = {{SIG_W{1'b0}}, sig_a_i} * {{SIG_W{1'b0}}, sig_b_i};
    assign carry = prod[PROD_W-1];
    assign mask  = keep_mask(width_i);

    // R5: place the leading 1 in the hidden position.
    assign frac_raw = carry ? prod[PROD_W-2 -: FRAC_W] : prod[PROD_W-3 -: FRAC_W];
    assign frac_o   = frac_raw & mask[FRAC_W-1:0];
    assign exp_o    = exp_i + SEXP_W'(carry);
endmodule

// File: rtl/fpm_mul_top.sv
module fpm_mul_top
    import fpm_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid_i,
    input  logic [66:0]       op_a_i,
    input  logic [66:0]       op_b_i,
    output logic              res_valid_o,
    output logic [66:0]       res_o,
    output logic              flag_zero_o,
    output logic              flag_inf_o,
    output logic              flag_nan_o,
    output logic              flag_denorm_o
);
    localparam logic signed [SEXP_W-1:0] EXP_TOP = SEXP_W'(EXP_MAX);
    localparam logic [FRAC_W-1:0] QNAN_FRAC = {1'b1, {(FRAC_W-1){1'b0}}};

    logic a_ill, a_auto, a_sign, b_ill, b_auto, b_sign;
    logic [EXP_W-1:0] a_exp, b_exp;
    logic [SIG_W-1:0] a_sig, b_sig;
    wid_t a_w, b_w, w_eff;
    cls_e a_cls, b_cls, cls_c;

    fpm_operand_decode u_dec_a (
        .word_i(op_a_i), .illegal_o(a_ill), .auto_o(a_auto), .sign_o(a_sign),
        .exp_o(a_exp), .sig_o(a_sig), .width_o(a_w), .cls_o(a_cls)
    );
    fpm_operand_decode u_dec_b (
        .word_i(op_b_i), .illegal_o(b_ill), .auto_o(b_auto), .sign_o(b_sign),
        .exp_o(b_exp), .sig_o(b_sig), .width_o(b_w), .cls_o(b_cls)
    );

    // R3: width resolution
    always_comb begin
        if (a_auto && b_auto) w_eff = (a_w > b_w) ? a_w : b_w;
        else                  w_eff = (a_w < b_w) ? a_w : b_w;
    end

    // R8, R9, R10: class combination in priority order
    always_comb begin
        if (a_ill || b_ill)                              cls_c = CLS_NAN;
        else if (a_cls == CLS_NAN || b_cls == CLS_NAN)   cls_c = CLS_NAN;
        else if ((a_cls == CLS_INF && b_cls == CLS_ZERO) ||
                 (a_cls == CLS_ZERO && b_cls == CLS_INF)) cls_c = CLS_NAN;
        else if (a_cls == CLS_INF || b_cls == CLS_INF)   cls_c = CLS_INF;
        else if (a_cls == CLS_ZERO || b_cls == CLS_ZERO) cls_c = CLS_ZERO;
        else                                             cls_c = CLS_NUM;
    end

    // Stage 1 registers
    logic                     s1_valid;
    cls_e                     s1_cls;
    logic                     s1_sign;
    logic [MODE_W-1:0]        s1_mode;
    logic signed [SEXP_W-1:0] s1_exp;
    logic [SIG_W-1:0]         s1_sig_a, s1_sig_b;
    wid_t                     s1_w;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1_valid <= 1'b0;
            s1_cls   <= CLS_NUM;
            s1_sign  <= 1'b0;
            s1_mode  <= '0;
            s1_exp   <= '0;
            s1_sig_a <= '0;
            s1_sig_b <= '0;
            s1_w     <= wid_t'(SIG_W);
        end else begin
            s1_valid <= in_valid_i;
            if (in_valid_i) begin
                s1_cls   <= cls_c;
                s1_sign  <= a_sign ^ b_sign;
                s1_mode  <= op_a_i[WORD_W-1 -: MODE_W];
                s1_exp   <= SEXP_W'(a_exp) + SEXP_W'(b_exp) - SEXP_W'(EXP_BIAS);
                s1_sig_a <= a_sig & keep_mask(w_eff);
                s1_sig_b <= b_sig & keep_mask(w_eff);
                s1_w     <= w_eff;
            end
        end
    end

    // Stage 2: multiply, normalize, pack
    logic [FRAC_W-1:0]        n_frac;
    logic signed [SEXP_W-1:0] n_exp;

    fpm_mant_core u_core (
        .sig_a_i(s1_sig_a), .sig_b_i(s1_sig_b), .width_i(s1_w),
        .exp_i(s1_exp), .frac_o(n_frac), .exp_o(n_exp)
    );

    logic [WORD_W-1:0] pk_word;
    logic [3:0]        pk_flags; // {denorm, nan, inf, zero}

    always_comb begin
        pk_word  = '0;
        pk_flags = '0;
        unique case (s1_cls)
            CLS_NAN: begin
                pk_word  = {s1_mode, 1'b0, EXP_W'(EXP_MAX), QNAN_FRAC};
                pk_flags = 4'b0100;
            end
            CLS_INF: begin
                pk_word  = {s1_mode, s1_sign, EXP_W'(EXP_MAX), {FRAC_W{1'b0}}};
                pk_flags = 4'b0010;
            end
            CLS_ZERO: begin
                pk_word  = {s1_mode, s1_sign, {EXP_W{1'b0}}, {FRAC_W{1'b0}}};
                pk_flags = 4'b0001;
            end
            CLS_NUM: begin
                if (n_exp >= EXP_TOP) begin
                    pk_word  = {s1_mode, s1_sign, EXP_W'(EXP_MAX), {FRAC_W{1'b0}}};
                    pk_flags = 4'b0010;
                end else if (n_exp <= 0) begin
                    pk_word  = {s1_mode, s1_sign, {EXP_W{1'b0}}, {FRAC_W{1'b0}}};
                    pk_flags = 4'b1001;
                end else begin
                    pk_word  = {s1_mode, s1_sign, n_exp[EXP_W-1:0], n_frac};
                    pk_flags = 4'b0000;
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            res_valid_o   <= 1'b0;
            res_o         <= '0;
            flag_zero_o   <= 1'b0;
            flag_inf_o    <= 1'b0;
            flag_nan_o    <= 1'b0;
            flag_denorm_o <= 1'b0;
        end else begin
            res_valid_o <= s1_valid;
            if (s1_valid) begin
                res_o         <= pk_word;
                flag_denorm_o <= pk_flags[3];
                flag_nan_o    <= pk_flags[2];
                flag_inf_o    <= pk_flags[1];
                flag_zero_o   <= pk_flags[0];
            end
        end
    end

    // Assertions
    a_r11_latency: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid_i |-> ##2 res_valid_o);
    a_r11_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid_o |-> $past(s1_valid));
    a_r11_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !s1_valid |=> $stable(res_o));
    a_r6_inf_encoding: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid_o && flag_inf_o) |-> (res_o[62:52] == 11'h7FF && res_o[51:0] == '0));
    a_r8_nan_encoding: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid_o && flag_nan_o) |-> (res_o[62:52] == 11'h7FF && res_o[51:0] != '0));
    a_r7_flush: assert property (@(posedge clk) disable iff (!rst_n)
        flag_denorm_o |-> (flag_zero_o && res_o[62:0] == '0));
    a_r10_one_class: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({flag_zero_o, flag_inf_o, flag_nan_o}));
endmodule

// File: tb/sim_fpm_mul_top.sv
module sim_fpm_mul_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid_i = 1'b0;
    logic [66:0] op_a_i = '0;
    logic [66:0] op_b_i = '0;
    logic        res_valid_o;
    logic [66:0] res_o;
    logic        flag_zero_o, flag_inf_o, flag_nan_o, flag_denorm_o;

    always #2 clk = ~clk; // 250 MHz

    fpm_mul_top u0 (
        .clk(clk), .rst_n(rst_n), .in_valid_i(in_valid_i),
        .op_a_i(op_a_i), .op_b_i(op_b_i), .res_valid_o(res_valid_o),
        .res_o(res_o), .flag_zero_o(flag_zero_o), .flag_inf_o(flag_inf_o),
        .flag_nan_o(flag_nan_o), .flag_denorm_o(flag_denorm_o)
    );

    typedef struct {
        logic [66:0] r;
        logic [3:0]  f;
        string       tag;
    } exp_t;

    exp_t exp_q[$];
    int tests = 0;
    int fails = 0;
    logic        seen = 1'b0;
    logic [66:0] last_r;
    logic [3:0]  last_f;
    logic [31:0] lfsr = 32'hACE1_2468;
    int cyc = 0;

    function automatic int width_of(input int mode, input logic [52:0] sig);
        int lst[5] = '{8, 16, 23, 36, 53};
        if (mode >= 1 && mode <= 5) return lst[mode-1];
        for (int i = 0; i < 5; i++) begin
            if ((sig & ((53'd1 << (53 - lst[i])) - 53'd1)) == 53'd0) return lst[i];
        end
        return 53;
    endfunction

    // Behavioural reference; flags = {denorm, nan, inf, zero}
    function automatic void ref_mul(input logic [66:0] a, input logic [66:0] b,
                                    output logic [66:0] r, output logic [3:0] f);
        int ma = int'(a[66:64]);
        int mb = int'(b[66:64]);
        int ea = int'(a[62:52]);
        int eb = int'(b[62:52]);
        logic sg = a[63] ^ b[63];
        logic [52:0] sa = {1'b1, a[51:0]};
        logic [52:0] sb = {1'b1, b[51:0]};
        bit a_nan = (ea == 2047) && (a[51:0] != 0);
        bit b_nan = (eb == 2047) && (b[51:0] != 0);
        bit a_inf = (ea == 2047) && (a[51:0] == 0);
        bit b_inf = (eb == 2047) && (b[51:0] == 0);
        bit a_zer = (ea == 0);
        bit b_zer = (eb == 0);
        int wa, wb, w, e;
        logic [105:0] p;
        logic [51:0] fr;
        if (ma > 5 || mb > 5 || a_nan || b_nan || (a_inf && b_zer) || (a_zer && b_inf)) begin
            r = {a[66:64], 1'b0, 11'h7FF, 52'h8000000000000}; f = 4'b0100; return;
        end
        if (a_inf || b_inf) begin r = {a[66:64], sg, 11'h7FF, 52'd0}; f = 4'b0010; return; end
        if (a_zer || b_zer) begin r = {a[66:64], sg, 63'd0}; f = 4'b0001; return; end
        wa = width_of(ma, sa);
        wb = width_of(mb, sb);
        if (ma == 0 && mb == 0) w = (wa > wb) ? wa : wb;
        else w = (wa < wb) ? wa : wb;
        sa = (sa >> (53 - w)) << (53 - w);
        sb = (sb >> (53 - w)) << (53 - w);
        p = {53'd0, sa} * {53'd0, sb};
        e = ea + eb - 1023;
        if (p[105]) begin fr = p[104:53]; e = e + 1; end
        else fr = p[103:52];
        fr = (fr >> (53 - w)) << (53 - w);
        if (e >= 2047) begin r = {a[66:64], sg, 11'h7FF, 52'd0}; f = 4'b0010; end
        else if (e <= 0) begin r = {a[66:64], sg, 63'd0}; f = 4'b1001; end
        else begin r = {a[66:64], sg, 11'(e), fr}; f = 4'b0000; end
    endfunction

    function automatic logic [66:0] mk(input int m, input bit s, input int e, input logic [51:0] fr);
        return {3'(m), s, 11'(e), fr};
    endfunction

    task automatic check(input bit ok, input string tag, input logic [66:0] act_r,
                         input logic [3:0] act_f, input logic [66:0] e_r, input logic [3:0] e_f);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h/%b expected=%h/%b", tag, act_r, act_f, e_r, e_f);
        end
    endtask

    task automatic op(input logic [66:0] a, input logic [66:0] b, input string tag);
        exp_t x;
        @(negedge clk);
        ref_mul(a, b, x.r, x.f);
        x.tag = tag;
        exp_q.push_back(x);
        op_a_i = a; op_b_i = b; in_valid_i = 1'b1;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid_i = 1'b0;
        end
    endtask

    // Compare on every clock, away from the active edge
    always @(negedge clk) begin
        if (rst_n) begin
            logic [3:0] af;
            af = {flag_denorm_o, flag_nan_o, flag_inf_o, flag_zero_o};
            if (res_valid_o) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R11 unexpected valid", res_o, af, '0, '0);
                end else begin
                    exp_t x;
                    x = exp_q.pop_front();
                    check(res_o === x.r && af === x.f, x.tag, res_o, af, x.r, x.f);
                end
                seen <= 1'b1;
                last_r <= res_o;
                last_f <= af;
            end else if (seen) begin
                check(res_o === last_r && af === last_f, "R11 hold", res_o, af, last_r, last_f);
            end
        end
    end

    // Watchdog
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 20000) begin
            tests++; fails++;
            $display("FAIL R11 watchdog expired");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check(res_valid_o == 1'b0 && res_o == '0 &&
              {flag_denorm_o, flag_nan_o, flag_inf_o, flag_zero_o} == 4'b0,
              "R11 reset", res_o, {flag_denorm_o, flag_nan_o, flag_inf_o, flag_zero_o}, '0, '0);
        rst_n = 1'b1;
        idle(2);

        // R1: each fixed width, same fraction
        for (int m = 1; m <= 5; m++)
            op(mk(m, 0, 1023, 52'hF3C5_A971_2468_B), mk(m, 0, 1030, 52'h9ABC_DEF0_1234_5), "R1 fixed width");
        op(mk(5, 0, 1023, 52'h8000000000000), mk(5, 0, 1023, 52'h8000000000000), "R1 R5 1.5x1.5");
        // R2: auto widths, lossless at different sizes
        op(mk(0, 0, 1000, 52'hA000000000000), mk(0, 0, 1010, 52'h3000000000000), "R2 auto 8");
        op(mk(0, 0, 1000, 52'hABCDE00000000), mk(0, 0, 1010, 52'h1000000000000), "R2 auto 23 vs 8");
        op(mk(0, 1, 1000, 52'hABCDEF1234000), mk(0, 0, 1010, 52'h0000000000001), "R2 auto 53");
        // R3: mixed modes
        op(mk(2, 0, 1100, 52'hFFFFFFFFFFFFF), mk(4, 0, 900, 52'hFFFFFFFFFFFFF), "R3 A narrower");
        op(mk(4, 0, 1100, 52'h123456789ABCD), mk(1, 0, 900, 52'hFEDCBA9876543), "R3 B narrower");
        op(mk(0, 0, 1100, 52'h123456789ABCD), mk(3, 0, 900, 52'hFEDCBA9876543), "R3 auto vs fixed");
        op(mk(3, 0, 1100, 52'h8000000000000), mk(0, 0, 900, 52'hFEDCBA9876543), "R3 fixed vs auto");
        // R4: signs
        op(mk(5, 1, 1023, 52'h1), mk(5, 0, 1023, 52'h2), "R4 neg x pos");
        op(mk(5, 1, 1023, 52'h1), mk(5, 1, 1023, 52'h2), "R4 neg x neg");
        // R5/R6/R7 boundaries with and without carry
        op(mk(5, 0, 2046, 52'h0), mk(5, 0, 1023, 52'h1), "R5 R6 top no carry");
        op(mk(5, 0, 2046, 52'hC000000000000), mk(5, 0, 1023, 52'hC000000000000), "R6 carry into overflow");
        op(mk(5, 1, 2000, 52'h0), mk(5, 0, 1100, 52'h0), "R6 overflow");
        op(mk(5, 0, 500, 52'hC000000000000), mk(5, 0, 523, 52'hC000000000000), "R5 R7 carry rescues");
        op(mk(5, 1, 500, 52'h1000000000000), mk(5, 0, 523, 52'h1000000000000), "R7 zero sum");
        op(mk(5, 0, 1, 52'h0), mk(5, 0, 1023, 52'h0), "R7 just normal");
        op(mk(2, 1, 300, 52'h5), mk(2, 0, 300, 52'h7), "R7 underflow");
        // R8: illegal modes
        op(mk(6, 1, 1023, 52'h1), mk(5, 0, 1023, 52'h1), "R8 mode 6 A");
        op(mk(1, 0, 1023, 52'h1), mk(7, 0, 1023, 52'h1), "R8 mode 7 B");
        // R9: NaN inputs, inf x zero
        op(mk(5, 1, 2047, 52'h4), mk(5, 0, 1023, 52'h0), "R9 nan in");
        op(mk(5, 0, 2047, 52'h0), mk(5, 1, 0, 52'h0), "R9 inf x zero");
        // R10: inf and zero
        op(mk(3, 1, 2047, 52'h0), mk(3, 0, 1023, 52'hFFF), "R10 inf x num");
        op(mk(3, 1, 2047, 52'h0), mk(3, 1, 2047, 52'h0), "R10 inf x inf");
        op(mk(4, 0, 0, 52'hFFFFF), mk(4, 1, 1050, 52'h77), "R10 subnormal as zero");
        idle(3);
        // R11 and all: pseudo-random mixed stream with gaps
        for (int i = 0; i < 300; i++) begin
            logic [66:0] a, b;
            lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
            a = mk(int'(lfsr[2:0]), lfsr[3], 880 + int'(lfsr[11:4]),
                   {lfsr, lfsr[31:12]} & ~((52'd1 << lfsr[17:12]) - 52'd1));
            lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
            b = mk((lfsr[2:0] > 5) ? 0 : int'(lfsr[2:0]), lfsr[3], 900 + int'(lfsr[11:4]),
                   {lfsr[19:0], lfsr} & ~((52'd1 << lfsr[22:17]) - 52'd1));
            op(a, b, "R1 R2 R3 R5 R11 mixed");
            if (lfsr[5]) idle(1);
        end
        idle(5);
        check(exp_q.size() == 0, "R11 all results delivered", 67'(exp_q.size()), 4'b0, '0, '0);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule